// File: doc/BRIEF.md
# Protection Entry Register Bank

This block holds the configuration state for sixteen memory protection entries. Each entry has an 8-bit configuration byte and an address register as wide as the machine word. Software reaches them through a control-register port: a 12-bit register number, a write strobe, write data and a combinational read-back. The configuration bytes are packed several to a register. At a 32-bit word width four bytes share each register. At a 64-bit word width eight bytes share each register, and only the even-numbered configuration registers exist.

Every write is legalized before it is stored. A locked byte keeps its old contents until reset, while the other bytes in the same register still take new values. A permission combination that allows writes but not reads has its write permission cleared. An address register refuses a write when its own entry is locked. It also refuses a write when the following entry is locked and in top-of-range mode, because that entry uses this address as its lower bound. A read after a write returns the stored, legalized value. The per-entry state is also driven out flat, for the address checker that sits beside this block.

Top module: `pmp_regbank`

## Requirements
- R1: Reset (synchronous, active low) clears every configuration byte, including its lock bit, and every address register to zero.
- R2: At a 32-bit word width, entry e's byte lives in register 0x3A0 + e/4 at bits [8*(e%4)+7 : 8*(e%4)]. It is also driven on `cfg_flat[8*e+7 : 8*e]`.
- R3: At a 64-bit word width, entries 0-7 live in register 0x3A0 and entries 8-15 in 0x3A2, at bits [8*(e%8)+7 : 8*(e%8)]. Registers 0x3A1 and 0x3A3 are unmapped there: no hit, a read returns zero, and a write changes no state.
- R4: Byte layout: bit 7 is the lock, bits [4:3] are the match mode (00 off, 01 top-of-range, 10 four-byte, 11 power-of-two region), bit 2 is execute, bit 1 is write and bit 0 is read. Bits [6:5] always read as zero.
- R5: A write that sets bit 1 with bit 0 clear is stored with bit 1 cleared.
- R6: Once a byte has bit 7 set, it ignores every write until reset. The other bytes of the same register still update.
- R7: Address register i sits at 0x3B0 + i and reads back the full word that was written to it.
- R8: A write to address register i is ignored while entry i is locked.
- R9: A write to address register i is ignored while entry i+1 is locked with mode 01. A locked entry i+1 in any other mode does not block the write.
- R10: Address register 15 is blocked only by entry 15's own lock.
- R11: A read of a configuration register after a write returns the legalized stored value, not the raw write data.
- R12: Any register number outside the mapped set gives `csr_hit` low and `csr_rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | Register number for read and write |
| csr_we | input | 1 | Write strobe; the write takes effect on the rising edge |
| csr_wdata | input | XLEN | Write data |
| csr_hit | output | 1 | The register number maps to a register in this bank |
| csr_rdata | output | XLEN | Combinational read-back of the addressed register |
| cfg_flat | output | 8*NUM_ENTRIES | All configuration bytes, entry e at [8e+7:8e] |
| addr_flat | output | XLEN*NUM_ENTRIES | All address registers, entry e at [XLEN*e+XLEN-1:XLEN*e] |

## Verification
The bench builds two copies side by side. One uses XLEN=32, where four bytes share a register and all four configuration registers exist. The other uses XLEN=64, where eight bytes share a register, the odd registers become unmapped, and full 64-bit address values can be written and read. Both use sixteen entries, so entry 15 is the last entry and its address-write rule can be exercised. Entries 3-4, 8-9 and 14-15 give neighbour pairs that show lock blocking in top-of-range mode and in another mode.

// File: rtl/pmp_bank_pkg.sv
// Package: shared types and legalization for the protection entry bank.
// Assumes configuration bytes of 8 bits with the field layout below.
package pmp_bank_pkg;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        logic [1:0] mode;
        logic       x;
        logic       w;
        logic       r;
    } pmp_cfg_t;

    localparam logic [1:0] MODE_OFF   = 2'b00;
    localparam logic [1:0] MODE_TOR   = 2'b01;
    localparam logic [1:0] MODE_NA4   = 2'b10;
    localparam logic [1:0] MODE_NAPOT = 2'b11;

    localparam logic [11:0] CFG_BASE  = 12'h3A0;
    localparam logic [11:0] ADDR_BASE = 12'h3B0;

    // Next stored value of a byte: a locked byte keeps its value; otherwise the
    // reserved bits are cleared and write-without-read loses its write bit.
    function automatic pmp_cfg_t legalize_cfg(pmp_cfg_t old_q, logic [7:0] raw);
        pmp_cfg_t res;
        if (old_q.lock) begin
            res = old_q;
        end else begin
            res      = pmp_cfg_t'(raw);
            res.rsvd = 2'b00;
            if (res.w && !res.r) begin
                res.w = 1'b0;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/pmp_csr_decode.sv
// Module: decodes a register number into a configuration-register hit with its
// slot index, or an address-register hit with its entry index.
// Assumes the configuration registers occupy slots 0..3 and the address
// registers occupy 0x3B0 upward, one per entry, with at most 16 entries.
module pmp_csr_decode #(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16
) (
    input  logic [11:0]                     csr_addr,
    output logic                            cfg_hit,
    output logic [1:0]                      cfg_slot,
    output logic                            addr_hit,
    output logic [$clog2(NUM_ENTRIES)-1:0]  addr_idx
);
    import pmp_bank_pkg::*;

    localparam int BYTES_PER  = XLEN / 8;
    localparam int STRIDE     = XLEN / 32;
    localparam int NUM_GROUPS = (NUM_ENTRIES + BYTES_PER - 1) / BYTES_PER;
    localparam int IDX_W      = $clog2(NUM_ENTRIES);

    // Configuration decode: a slot is valid when it is aligned to the stride
    // and belongs to a group that actually holds entries.
    always_comb begin
        cfg_slot = csr_addr[1:0];
        cfg_hit  = 1'b0;
        if (csr_addr[11:2] == CFG_BASE[11:2]) begin
            if ((int'(csr_addr[1:0]) % STRIDE) == 0 &&
                (int'(csr_addr[1:0]) / STRIDE) < NUM_GROUPS) begin
                cfg_hit = 1'b1;
            end
        end
    end

    // Address-register decode: one register number per entry.
    always_comb begin
        addr_idx = csr_addr[IDX_W-1:0];
        addr_hit = (csr_addr[11:4] == ADDR_BASE[11:4]) &&
                   (int'(csr_addr[3:0]) < NUM_ENTRIES);
    end

endmodule

// File: rtl/pmp_cfg_entry.sv
// Module: one configuration byte with lock and legalization on write.
// Assumes the write strobe already selects this byte's register.
module pmp_cfg_entry (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [7:0]               wbyte,
    output pmp_bank_pkg::pmp_cfg_t   cfg_o
);
    import pmp_bank_pkg::*;

    pmp_cfg_t cfg_q;

    // Byte storage: cleared by reset, legalized on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= legalize_cfg(cfg_q, wbyte);
        end
    end

    assign cfg_o = cfg_q;

    // R6: a locked byte does not change until reset.
    a_r6_locked_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock |=> $stable(cfg_q));

    // R5: write permission never stored without read permission.
    a_r5_no_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_q.w && !cfg_q.r));

    // R4: reserved bits always zero.
    a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.rsvd == 2'b00);

endmodule

// File: rtl/pmp_addr_entry.sv
// Module: one address register whose writes are gated by its own lock and by
// the following entry being locked in top-of-range mode.
// Assumes next_tor_lock is tied low for the last entry.
module pmp_addr_entry #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    input  logic            own_lock,
    input  logic            next_tor_lock,
    output logic [XLEN-1:0] addr_o
);
    logic [XLEN-1:0] addr_q;
    logic            blocked;

    // Write gate: either lock condition refuses the write.
    assign blocked = own_lock || next_tor_lock;

    // Address storage: cleared by reset, written when not blocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (we && !blocked) begin
            addr_q <= wdata;
        end
    end

    assign addr_o = addr_q;

    // R8: own lock keeps the address unchanged.
    a_r8_own_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        own_lock |=> $stable(addr_q));

    // R9: a locked top-of-range successor keeps the address unchanged.
    a_r9_tor_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        next_tor_lock |=> $stable(addr_q));

    // R7: an unblocked write lands in the register.
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !blocked) |=> (addr_q == $past(wdata)));

endmodule

// File: rtl/pmp_regbank.sv
// Module: top of the protection entry register bank. It decodes register
// numbers, routes packed configuration bytes to per-entry storage, gates
// address writes by lock state, and muxes the read-back.
// Assumes XLEN is 32 or 64 and NUM_ENTRIES is at most 16.
module pmp_regbank #(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [11:0]                   csr_addr,
    input  logic                          csr_we,
    input  logic [XLEN-1:0]               csr_wdata,
    output logic                          csr_hit,
    output logic [XLEN-1:0]               csr_rdata,
    output logic [8*NUM_ENTRIES-1:0]      cfg_flat,
    output logic [XLEN*NUM_ENTRIES-1:0]   addr_flat
);
    import pmp_bank_pkg::*;

    localparam int BYTES_PER = XLEN / 8;
    localparam int STRIDE    = XLEN / 32;
    localparam int IDX_W     = $clog2(NUM_ENTRIES);

    logic             cfg_hit;
    logic [1:0]       cfg_slot;
    logic             addr_hit;
    logic [IDX_W-1:0] addr_idx;

    pmp_cfg_t         cfg_q  [NUM_ENTRIES];
    logic [XLEN-1:0]  addr_q [NUM_ENTRIES];

    pmp_csr_decode #(
        .XLEN        (XLEN),
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_decode (
        .csr_addr (csr_addr),
        .cfg_hit  (cfg_hit),
        .cfg_slot (cfg_slot),
        .addr_hit (addr_hit),
        .addr_idx (addr_idx)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        localparam int SLOT = (e / BYTES_PER) * STRIDE;
        localparam int LANE = e % BYTES_PER;

        logic cfg_we;
        logic addr_we;
        logic next_tor_lock;

        // Byte strobe: this entry's register is addressed.
        assign cfg_we  = csr_we && cfg_hit && (int'(cfg_slot) == SLOT);
        // Address strobe: this entry's address register is addressed.
        assign addr_we = csr_we && addr_hit && (int'(addr_idx) == e);

        if (e == NUM_ENTRIES - 1) begin : g_last
            assign next_tor_lock = 1'b0;
        end else begin : g_mid
            assign next_tor_lock = cfg_q[e+1].lock && (cfg_q[e+1].mode == MODE_TOR);
        end

        pmp_cfg_entry u_cfg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (cfg_we),
            .wbyte (csr_wdata[8*LANE +: 8]),
            .cfg_o (cfg_q[e])
        );

        pmp_addr_entry #(
            .XLEN (XLEN)
        ) u_addr (
            .clk           (clk),
            .rst_n         (rst_n),
            .we            (addr_we),
            .wdata         (csr_wdata),
            .own_lock      (cfg_q[e].lock),
            .next_tor_lock (next_tor_lock),
            .addr_o        (addr_q[e])
        );

        assign cfg_flat[8*e +: 8]       = cfg_q[e];
        assign addr_flat[XLEN*e +: XLEN] = addr_q[e];
    end

    // Read-back mux: packs the bytes of the addressed slot, or returns one
    // address register, or zero for an unmapped number.
    always_comb begin
        csr_rdata = '0;
        if (cfg_hit) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                if (int'(cfg_slot) == (e / BYTES_PER) * STRIDE) begin
                    csr_rdata[8*(e % BYTES_PER) +: 8] = cfg_q[e];
                end
            end
        end else if (addr_hit) begin
            csr_rdata = addr_q[addr_idx];
        end
    end

    assign csr_hit = cfg_hit || addr_hit;

    // R12: unmapped register numbers read as zero.
    a_r12_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_hit |-> (csr_rdata == '0));

    // R3: odd configuration slots are unmapped at a 64-bit width.
    a_r3_odd_slot_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        ((XLEN == 64) && (csr_addr[11:2] == CFG_BASE[11:2]) && csr_addr[0])
        |-> !csr_hit);

endmodule

// File: tb/pmp_regbank_test.sv
`timescale 1ns/1ps
module pmp_regbank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;

    logic [11:0]  a32 = '0, a64 = '0;
    logic         we32 = 1'b0, we64 = 1'b0;
    logic [31:0]  wd32 = '0, rd32;
    logic [63:0]  wd64 = '0, rd64;
    logic         hit32, hit64;
    logic [127:0] cf32, cf64;
    logic [511:0] af32;
    logic [1023:0] af64;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    pmp_regbank #(.XLEN(32), .NUM_ENTRIES(16)) uut (
        .clk(clk), .rst_n(rst_n), .csr_addr(a32), .csr_we(we32),
        .csr_wdata(wd32), .csr_hit(hit32), .csr_rdata(rd32),
        .cfg_flat(cf32), .addr_flat(af32)
    );

    pmp_regbank #(.XLEN(64), .NUM_ENTRIES(16)) uut64 (
        .clk(clk), .rst_n(rst_n), .csr_addr(a64), .csr_we(we64),
        .csr_wdata(wd64), .csr_hit(hit64), .csr_rdata(rd64),
        .cfg_flat(cf64), .addr_flat(af64)
    );

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(bit wide, logic [11:0] addr, logic [63:0] data);
        @(negedge clk);
        if (wide) begin a64 = addr; wd64 = data; we64 = 1'b1; end
        else begin a32 = addr; wd32 = data[31:0]; we32 = 1'b1; end
        @(negedge clk);
        we32 = 1'b0;
        we64 = 1'b0;
    endtask

    task automatic rd(bit wide, logic [11:0] addr, output logic [63:0] data, output logic hit);
        @(negedge clk);
        if (wide) begin a64 = addr; #1; data = rd64; hit = hit64; end
        else begin a32 = addr; #1; data = {32'h0, rd32}; hit = hit32; end
    endtask

    task automatic t_reset();
        logic [63:0] d; logic h;
        for (int i = 0; i < 4; i++) begin
            rd(0, 12'h3A0 + 12'(i), d, h);
            check("R1 cfg reg zero after reset", d, 64'h0);
        end
        rd(0, 12'h3B7, d, h);
        check("R1 addr reg zero after reset", d, 64'h0);
        check("R1 cfg_flat zero", {32'h0, cf64[31:0]}, 64'h0);
    endtask

    task automatic t_pack32();
        logic [63:0] d; logic h;
        wr(0, 12'h3A0, 64'h180F0301);
        rd(0, 12'h3A0, d, h);
        check("R2 packed read-back", d, 64'h180F0301);
        check("R2 entry2 on cfg_flat", {56'h0, cf32[23:16]}, 64'h0F);
        check("R2 hit on 0x3A0", {63'h0, h}, 64'h1);
    endtask

    task automatic t_legalize();
        logic [63:0] d; logic h;
        wr(0, 12'h3A1, 64'h60606060);
        rd(0, 12'h3A1, d, h);
        check("R4 reserved bits read zero", d, 64'h0);
        wr(0, 12'h3A2, 64'h00000602);
        rd(0, 12'h3A2, d, h);
        check("R5 R11 write-only cleared", d, 64'h00000400);
    endtask

    task automatic t_addr_rw();
        logic [63:0] d; logic h;
        wr(0, 12'h3B5, 64'hDEADBEEF);
        rd(0, 12'h3B5, d, h);
        check("R7 addr reg read-back", d, 64'hDEADBEEF);
    endtask

    task automatic t_lock();
        logic [63:0] d; logic h;
        wr(0, 12'h3A1, 64'h00000181);
        wr(0, 12'h3A1, 64'h03030303);
        rd(0, 12'h3A1, d, h);
        check("R6 R11 locked byte kept, others updated", d, 64'h03030381);
        wr(0, 12'h3B4, 64'h12345678);
        rd(0, 12'h3B4, d, h);
        check("R8 own lock blocks addr write", d, 64'h0);
        wr(0, 12'h3B3, 64'h0000AAAA);
        rd(0, 12'h3B3, d, h);
        check("R9 locked non-TOR successor does not block", d, 64'h0000AAAA);
    endtask

    task automatic t_tor();
        logic [63:0] d; logic h;
        wr(0, 12'h3B8, 64'h55);
        wr(0, 12'h3A2, 64'h00008900);
        wr(0, 12'h3B8, 64'h77);
        rd(0, 12'h3B8, d, h);
        check("R9 TOR-locked successor blocks", d, 64'h55);
        wr(0, 12'h3B9, 64'h99);
        rd(0, 12'h3B9, d, h);
        check("R8 entry9 own lock", d, 64'h0);
    endtask

    task automatic t_last();
        logic [63:0] d; logic h;
        wr(0, 12'h3BE, 64'h22);
        wr(0, 12'h3BF, 64'h11);
        rd(0, 12'h3BF, d, h);
        check("R10 unlocked last entry writes", d, 64'h11);
        wr(0, 12'h3A3, 64'h88000000);
        wr(0, 12'h3BE, 64'h33);
        wr(0, 12'h3BF, 64'h44);
        rd(0, 12'h3BE, d, h);
        check("R9 entry14 blocked by entry15 TOR lock", d, 64'h22);
        rd(0, 12'h3BF, d, h);
        check("R10 last entry blocked by own lock", d, 64'h11);
    endtask

    task automatic t_miss();
        logic [63:0] d; logic h;
        rd(0, 12'h3C0, d, h);
        check("R12 miss rdata", d, 64'h0);
        check("R12 miss hit", {63'h0, h}, 64'h0);
        rd(0, 12'h39F, d, h);
        check("R12 miss below cfg", {63'h0, h}, 64'h0);
    endtask

    task automatic t_relock();
        logic [63:0] d; logic h;
        do_reset();
        rd(0, 12'h3A1, d, h);
        check("R1 lock cleared by reset", d, 64'h0);
        wr(0, 12'h3A1, 64'h03030303);
        rd(0, 12'h3A1, d, h);
        check("R6 byte writable after reset", d, 64'h03030303);
    endtask

    task automatic t_wide();
        logic [63:0] d; logic h;
        wr(1, 12'h3A0, 64'h1F1D19180F0D0901);
        rd(1, 12'h3A0, d, h);
        check("R3 64-bit packing slot0", d, 64'h1F1D19180F0D0901);
        check("R3 entry7 on cfg_flat", {56'h0, cf64[63:56]}, 64'h1F);
        wr(1, 12'h3A2, 64'h0000000000000301);
        rd(1, 12'h3A2, d, h);
        check("R3 64-bit packing slot2", d, 64'h0000000000000301);
        wr(1, 12'h3A1, 64'hFFFFFFFFFFFFFFFF);
        rd(1, 12'h3A1, d, h);
        check("R3 odd slot reads zero", d, 64'h0);
        check("R3 odd slot no hit", {63'h0, h}, 64'h0);
        rd(1, 12'h3A0, d, h);
        check("R3 odd write left slot0", d, 64'h1F1D19180F0D0901);
        rd(1, 12'h3A2, d, h);
        check("R3 odd write left slot2", d, 64'h0000000000000301);
        wr(1, 12'h3B0, 64'h0123456789ABCDEF);
        rd(1, 12'h3B0, d, h);
        check("R7 full 64-bit address", d, 64'h0123456789ABCDEF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, run hung");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_pack32();
        t_legalize();
        t_addr_rw();
        t_lock();
        t_tor();
        t_last();
        t_miss();
        t_wide();
        t_relock();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule